// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides what the system does when the core asks to go quiet. It holds one 8-bit control byte on a simple register bus with read and write strobes, and it accepts byte, halfword and word accesses. Two bits in that byte matter. The deep-select bit picks where a sleep request leads. The float bit picks whether the I/O pins are released to high impedance once the deep state is reached. The five low bits are fixed at one and the bit just below the float bit is fixed at zero.

A running watchdog must not be able to drop the system into deep standby or float the pins. While the watchdog-running input is high, a write may clear either mode bit but cannot set it. A single-cycle sleep request moves the mode machine from RUN to either LIGHT_SLEEP or DEEP_STANDBY, according to the deep-select bit. A wake pulse brings it back to RUN. The machine has three states:

- `ST_RUN` (code 00)
- `ST_SLEEP` (code 01)
- `ST_STANDBY` (code 10)

It has four transitions:

- RUN to SLEEP: sleep request while the deep-select bit is 0.
- RUN to STANDBY: sleep request while the deep-select bit is 1.
- SLEEP to RUN: wake.
- STANDBY to RUN: wake.

Reset from any state goes to RUN.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode code is 00 (RUN), `pin_hiz` is all zeros and a word read of the register returns 0x0000001F.
- R2: Register bits 4..0 always read as 1 and bit 5 always reads as 0, whatever value is written.
- R3: A write with data bit 7 = 1 while `wdt_run` is 1 leaves the deep-select bit (bit 7) unchanged; with `wdt_run` = 0 it sets it.
- R4: A write with data bit 6 = 1 while `wdt_run` is 1 leaves the float bit (bit 6) unchanged; with `wdt_run` = 0 it sets it.
- R5: A write with data bit 7 or bit 6 equal to 0 clears that bit, whatever the value of `wdt_run`.
- R6: The register sits in byte lane 0, which is `bus_wdata`/`bus_rdata` bits 7..0. A word access (`bus_size` 2) always hits it. A halfword access (`bus_size` 1) hits it only when `bus_addr_lo[1]` is 0. A byte access (`bus_size` 0) hits it only when `bus_addr_lo` is 0. Size code 3 never hits it. A miss changes nothing and reads 0, and every unused read bit is 0.
- R7: In RUN, a sleep request with the deep-select bit at 0 gives mode code 01 (SLEEP) after the next clock edge.
- R8: In RUN, a sleep request with the deep-select bit at 1 gives mode code 10 (STANDBY) after the next clock edge.
- R9: In SLEEP or STANDBY, a wake pulse gives mode code 00 after the next clock edge. `pin_hiz` returns to all zeros on that same edge.
- R10: `pin_hiz` is all ones exactly while in STANDBY, if the float bit was 1 when standby was entered. Otherwise it is all zeros, and it is never asserted in SLEEP.
- R11: A sleep request outside RUN and a wake pulse in RUN have no effect on the mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register address decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_addr_lo | input | 2 | Low two address bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wdt_run | input | 1 | Watchdog is running |
| sleep_req | input | 1 | Sleep request pulse from the core |
| wake | input | 1 | Wake pulse (interrupt or reset source) |
| mode_code | output | 2 | Current mode: 00 run, 01 sleep, 10 standby |
| pin_hiz | output | NPIN | Per-pin high-impedance override |

## Verification
The assertions assume that every input is known and sampled at the rising edge once reset is released. They also assume that `wdt_run` is valid in the same cycle as the write it gates. The bench changes inputs only on the falling edge. It keeps `sleep_req` and `wake` to single-cycle pulses and never drives them in the same cycle. The random mix of writes, reads, requests and wakes is built from those pulses, so it stays within these assumptions.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'b00,
        ST_SLEEP   = 2'b01,
        ST_STANDBY = 2'b10
    } pmc_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [4:0] FIXED_ONES = 5'h1F;
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pmc_pkg::*;
#(
    parameter int DW   = 32,
    parameter int LANE = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_size,
    input  logic [1:0]    bus_addr_lo,
    input  logic [DW-1:0] bus_wdata,
    input  logic          wdt_run,
    output logic [DW-1:0] bus_rdata,
    output logic          sby_q,
    output logic          hiz_q
);
    localparam int NLANE = DW / 8;
    localparam logic [1:0] LANE_IDX = 2'(LANE);

    logic       hit;
    logic [7:0] wbyte;
    logic [7:0] rbyte;

    always_comb begin
        unique case (bus_size)
            SZ_WORD: hit = bus_sel;
            SZ_HALF: hit = bus_sel && (bus_addr_lo[1] == LANE_IDX[1]);
            SZ_BYTE: hit = bus_sel && (bus_addr_lo == LANE_IDX);
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        wbyte = '0;
        for (int l = 0; l < NLANE; l++) begin
            if (l == LANE) wbyte = bus_wdata[8*l +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sby_q <= 1'b0;
            hiz_q <= 1'b0;
        end else if (hit && bus_wr) begin
            sby_q <= wbyte[7] ? (wdt_run ? sby_q : 1'b1) : 1'b0;
            hiz_q <= wbyte[6] ? (wdt_run ? hiz_q : 1'b1) : 1'b0;
        end
    end

    assign rbyte = {sby_q, hiz_q, 1'b0, FIXED_ONES};

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_rlane
            if (g == LANE) begin : g_reg
                assign bus_rdata[8*g +: 8] = (hit && bus_rd) ? rbyte : 8'h00;
            end else begin : g_zero
                assign bus_rdata[8*g +: 8] = 8'h00;
            end
        end
    endgenerate
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake,
    input  logic       sby_q,
    input  logic       hiz_q,
    output logic [1:0] mode_code,
    output logic       float_en
);
    pmc_state_e state_q, state_d;
    logic       float_q, float_d;

    always_comb begin
        state_d = state_q;
        float_d = float_q;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_req) begin
                    state_d = sby_q ? ST_STANDBY : ST_SLEEP;
                    float_d = sby_q & hiz_q;
                end
            end
            ST_SLEEP, ST_STANDBY: begin
                if (wake) begin
                    state_d = ST_RUN;
                    float_d = 1'b0;
                end
            end
            default: begin
                state_d = ST_RUN;
                float_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            float_q <= 1'b0;
        end else begin
            state_q <= state_d;
            float_q <= float_d;
        end
    end

    always_comb begin
        mode_code = state_q;
        float_en  = (state_q == ST_STANDBY) && float_q;
    end
endmodule

// File: rtl/pmc_pin_ovr.sv
module pmc_pin_ovr #(
    parameter int NPIN = 16
) (
    input  logic            float_en,
    output logic [NPIN-1:0] pin_hiz
);
    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            assign pin_hiz[p] = float_en;
        end
    endgenerate
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int DW   = 32,
    parameter int LANE = 0,
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [1:0]      bus_size,
    input  logic [1:0]      bus_addr_lo,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            wdt_run,
    input  logic            sleep_req,
    input  logic            wake,
    output logic [1:0]      mode_code,
    output logic [NPIN-1:0] pin_hiz
);
    logic sby_q;
    logic hiz_q;
    logic float_en;

    pmc_ctrl_reg #(.DW(DW), .LANE(LANE)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_size   (bus_size),
        .bus_addr_lo(bus_addr_lo),
        .bus_wdata  (bus_wdata),
        .wdt_run    (wdt_run),
        .bus_rdata  (bus_rdata),
        .sby_q      (sby_q),
        .hiz_q      (hiz_q)
    );

    pmc_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_req(sleep_req),
        .wake     (wake),
        .sby_q    (sby_q),
        .hiz_q    (hiz_q),
        .mode_code(mode_code),
        .float_en (float_en)
    );

    pmc_pin_ovr #(.NPIN(NPIN)) u_ovr (
        .float_en(float_en),
        .pin_hiz (pin_hiz)
    );
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
    parameter int NPIN = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wdt_run,
    input logic            sleep_req,
    input logic            wake,
    input logic [1:0]      mode_code,
    input logic [NPIN-1:0] pin_hiz,
    input logic            sby_q,
    input logic            hiz_q
);
    // R3
    sby_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_run && !sby_q) |=> !sby_q);

    // R4
    hiz_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_run && !hiz_q) |=> !hiz_q);

    // R7
    to_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 2'b00 && sleep_req && !sby_q) |=> mode_code == 2'b01);

    // R8
    to_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 2'b00 && sleep_req && sby_q) |=> mode_code == 2'b10);

    // R9
    wake_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code != 2'b00 && wake) |=> (mode_code == 2'b00 && pin_hiz == '0));

    // R10
    hiz_only_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_hiz != '0) |-> (mode_code == 2'b10 && pin_hiz == '1));

    // R11
    sleep_no_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 2'b01 && !wake) |=> mode_code == 2'b01);

    // R11
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_code != 2'b11);
endmodule

bind pwr_mode_ctrl pmc_chk #(.NPIN(NPIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdt_run  (wdt_run),
    .sleep_req(sleep_req),
    .wake     (wake),
    .mode_code(mode_code),
    .pin_hiz  (pin_hiz),
    .sby_q    (sby_q),
    .hiz_q    (hiz_q)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
    localparam int NPIN = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]      bus_size = 2'd2, bus_addr_lo = 2'd0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            wdt_run = 1'b0, sleep_req = 1'b0, wake = 1'b0;
    logic [1:0]      mode_code;
    logic [NPIN-1:0] pin_hiz;

    int n_tests = 0;
    int n_fail  = 0;

    logic       m_sby = 1'b0, m_hiz = 1'b0, m_float = 1'b0;
    logic [1:0] m_mode = 2'b00;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.NPIN(NPIN)) u_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_size(bus_size), .bus_addr_lo(bus_addr_lo),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_run(wdt_run),
        .sleep_req(sleep_req), .wake(wake), .mode_code(mode_code),
        .pin_hiz(pin_hiz)
    );

    function automatic logic hit_f(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'd2:    return 1'b1;
            2'd1:    return a[1] == 1'b0;
            2'd0:    return a == 2'd0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [1:0] a);
        return hit_f(sz, a) ? {24'h0, m_sby, m_hiz, 1'b0, 5'h1F} : 32'h0;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic chk_mode(input string tag);
        logic [NPIN-1:0] ehiz;
        ehiz = (m_mode == 2'b10 && m_float) ? '1 : '0;
        chk(mode_code == m_mode, tag, 32'(mode_code), 32'(m_mode));
        chk(pin_hiz == ehiz, {tag, " pin_hiz"}, 32'(pin_hiz), 32'(ehiz));
    endtask

    task automatic do_write(input logic [1:0] sz, input logic [1:0] a, input logic [31:0] d, input logic wd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_size = sz; bus_addr_lo = a;
        bus_wdata = d; wdt_run = wd;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; wdt_run = 1'b0;
        if (hit_f(sz, a)) begin
            m_sby = d[7] ? (wd ? m_sby : 1'b1) : 1'b0;
            m_hiz = d[6] ? (wd ? m_hiz : 1'b1) : 1'b0;
        end
    endtask

    task automatic do_read(input logic [1:0] sz, input logic [1:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_size = sz; bus_addr_lo = a;
        #1;
        e = exp_read(sz, a);
        chk(bus_rdata == e, tag, bus_rdata, e);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic do_sleep(input string tag);
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        if (m_mode == 2'b00) begin
            m_mode  = m_sby ? 2'b10 : 2'b01;
            m_float = m_sby & m_hiz;
        end
        chk_mode(tag);
    endtask

    task automatic do_wake(input string tag);
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        if (m_mode != 2'b00) begin
            m_mode  = 2'b00;
            m_float = 1'b0;
        end
        chk_mode(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_mode("R1 reset mode");
        do_read(2'd2, 2'd0, "R1 reset value");

        // R3 / R4 blocked while watchdog runs
        do_write(2'd2, 2'd0, 32'hFFFF_FFC0, 1'b1);
        do_read(2'd2, 2'd0, "R3 R4 set blocked");
        // R2 fixed bits with all-zero write
        do_write(2'd0, 2'd0, 32'h0000_0000, 1'b0);
        do_read(2'd0, 2'd0, "R2 fixed bits zero write");
        // R3 / R4 set allowed
        do_write(2'd0, 2'd0, 32'h0000_00E0, 1'b0);
        do_read(2'd2, 2'd0, "R2 R3 R4 set allowed");
        // R5 clear while watchdog runs
        do_write(2'd2, 2'd0, 32'h0000_0080, 1'b1);
        do_read(2'd2, 2'd0, "R5 clear bit6 under watchdog");
        // R6 misses
        do_write(2'd0, 2'd1, 32'h0000_0000, 1'b0);
        do_read(2'd2, 2'd0, "R6 byte offset 1 write missed");
        do_write(2'd1, 2'd2, 32'h0000_0000, 1'b0);
        do_read(2'd2, 2'd0, "R6 half offset 2 write missed");
        do_write(2'd3, 2'd0, 32'h0000_0000, 1'b0);
        do_read(2'd3, 2'd0, "R6 size 3 read zero");
        do_read(2'd0, 2'd3, "R6 byte offset 3 read zero");
        do_read(2'd1, 2'd0, "R6 half offset 0 hit");

        // R8 standby without float
        do_sleep("R8 enter standby");
        do_sleep("R11 sleep_req in standby");
        do_wake("R9 wake from standby");
        do_wake("R11 wake in run");
        // R10 standby with float
        do_write(2'd2, 2'd0, 32'h0000_00C0, 1'b0);
        do_sleep("R10 standby float");
        do_wake("R9 wake drops float");
        // R7 sleep with float bit set but deep-select clear
        do_write(2'd2, 2'd0, 32'h0000_0040, 1'b0);
        do_sleep("R7 R10 enter sleep");
        do_sleep("R11 sleep_req in sleep");
        do_wake("R9 wake from sleep");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: do_write(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                            $urandom, 1'($urandom_range(0, 1)));
                1: do_read(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                           "R2 R6 random read");
                2: do_sleep("R7 R8 R10 random sleep");
                3: do_wake("R9 R11 random wake");
                default: begin
                    @(negedge clk);
                    chk_mode("R10 R11 idle");
                end
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule